// File: doc/BRIEF.md
# Extended Store and Sign-Extend Sequencer

This block takes instructions one byte at a time over a valid/ready channel. It decodes five opcodes: a word store and a byte store, each with an indirect and an indexed form, and a sign extension from word to long. It gathers the operand bytes of each instruction. It reads the registers it needs through an asynchronous-read register-file port. Then it either sends one memory write request or writes one register back.

A store forms a 24-bit effective address. In the indirect form this is the address register alone. In the indexed form it is the address register plus a signed 24-bit displacement. With the narrow-address input high, the address is formed inside a 20-bit space, and a displacement outside the signed 20-bit range is rejected. The sign extension copies bit 15 of a 32-bit register into its upper half and updates the arithmetic flags. The store instructions leave every flag untouched.

The input channel is held off while the block computes and while a write request waits for acceptance. An unknown opcode byte is reported and dropped, and the block then expects a new opcode.

Top module: `xst_seq`

## Requirements
- R1: Instruction formats. Opcode 0x1C (word) and 0x1E (byte) are indirect stores of 3 bytes: opcode, address register number, source register number. Opcode 0x1D (word) and 0x1F (byte) are indexed stores of 6 bytes: opcode, address register number, displacement bits 7..0, bits 15..8, bits 23..16, source register number. Opcode 0x06 is followed by one register number. Each complete store issues exactly one write request.
- R2: An indirect store writes to bits 23..0 of the address register. In narrow mode it writes to bits 19..0 of the address register, with the upper address bits zero.
- R3: With narrow mode low, an indexed store writes to (address register bits 23..0 + displacement) modulo 2^24.
- R4: With narrow mode high, an indexed store writes to (address register bits 19..0 + displacement bits 19..0) modulo 2^20, and mem_wr_addr bits 23..20 are zero.
- R5: With narrow mode high, an indexed displacement outside -524288..+524287 raises range_err for one cycle. No write is issued, and the block returns to waiting for an opcode.
- R6: A word store sends bits 15..0 of the source register with strobe 2'b11. A byte store sends {8'h00, bits 7..0 of the source register} with strobe 2'b01.
- R7: A write request keeps its address, data and strobe unchanged until mem_wr_ready is seen. in_ready is low while the request is pending.
- R8: Sign extension writes the same register back for one cycle with rf_wr_en. Bits 15..0 are unchanged, and bits 31..16 are all ones when bit 15 is 1 and all zeros otherwise.
- R9: Sign extension sets flag_z when the 32-bit result is zero and sets flag_n to result bit 31. It clears flag_c and flag_v and leaves flag_vt and flag_st unchanged.
- R10: Stores, illegal opcodes and range errors leave all six flags unchanged.
- R11: Any other opcode byte raises illegal_op for one cycle and causes no write. The next byte is taken as an opcode.
- R12: Synchronous reset drops a partly received instruction. It sets in_ready high, mem_wr_valid and rf_wr_en low, and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr20_en | input | 1 | Selects the 20-bit address space |
| in_valid | input | 1 | Instruction byte valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| rf_rd_addr | output | 8 | Register-file read address |
| rf_rd_data | input | 32 | Register-file read data (asynchronous read) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_addr | output | 8 | Register-file write address |
| rf_wr_data | output | 32 | Register-file write data |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | 24 | Write address |
| mem_wr_data | output | 16 | Write data |
| mem_wr_strb | output | 2 | Byte strobes |
| range_err | output | 1 | Displacement out of range pulse |
| illegal_op | output | 1 | Unknown opcode pulse |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_vt | output | 1 | Sticky overflow flag |
| flag_st | output | 1 | Sticky bit flag |

## Verification
On every cycle, the assertions check the handshake on the write port: the request stays stable, input is stalled while it waits, the strobe has one of its two shapes, and the byte lane is zero padded. They also check that flags move only on a sign-extension write-back, that C and V read zero there, and that error and illegal pulses never coincide with a write. The actual addresses require the bench's scenarios: modulo-2^24 and modulo-2^20 wrap, the edges of the displacement range in narrow mode, and decoding of the variable-length formats. The same holds for the sign-extension results and Z/N values, and for recovery after a reset in the middle of an instruction.

// File: rtl/xst_pkg.sv
package xst_pkg;
  localparam logic [7:0] OPC_STW_IND = 8'h1C;
  localparam logic [7:0] OPC_STW_IDX = 8'h1D;
  localparam logic [7:0] OPC_STB_IND = 8'h1E;
  localparam logic [7:0] OPC_STB_IDX = 8'h1F;
  localparam logic [7:0] OPC_SEXT    = 8'h06;

  typedef enum logic [3:0] {
    SQ_OPC,   // waiting for an opcode byte
    SQ_AREG,  // address register number
    SQ_DISP,  // displacement bytes, low first
    SQ_SREG,  // source register number
    SQ_XREG,  // sign-extend register number
    SQ_BASE,  // address register on read port, form address
    SQ_SRC,   // source register on read port, launch write
    SQ_WAIT,  // write pending
    SQ_XRD    // sign-extend write-back
  } sq_state_e;
endpackage

// File: rtl/xst_ea_calc.sv
module xst_ea_calc #(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 20
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] disp,
  input  logic              use_disp,
  input  logic              narrow,
  output logic [ADDR_W-1:0] ea,
  output logic              out_of_range
);
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] wide_sum;

  assign offs     = use_disp ? disp : '0;
  assign wide_sum = base + offs;

  generate
    if (NARROW_W < ADDR_W) begin : g_narrow
      logic [NARROW_W-1:0]       nsum;
      logic [ADDR_W-NARROW_W:0]  hi;
      logic                      fits;
      assign nsum = base[NARROW_W-1:0] + offs[NARROW_W-1:0];
      assign hi   = disp[ADDR_W-1:NARROW_W-1];
      assign fits = (&hi) | ~(|hi);
      assign ea   = narrow ? {{(ADDR_W-NARROW_W){1'b0}}, nsum} : wide_sum;
      assign out_of_range = narrow & use_disp & ~fits;
    end else begin : g_wide_only
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign ea            = wide_sum;
      assign out_of_range  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/xst_sext.sv
module xst_sext #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val,
  output logic [DATA_W-1:0] res,
  output logic              is_zero,
  output logic              is_neg
);
  localparam int HALF = DATA_W / 2;

  logic unused_hi;
  assign unused_hi = ^val[DATA_W-1:HALF];

  assign res     = {{HALF{val[HALF-1]}}, val[HALF-1:0]};
  assign is_zero = (res == '0);
  assign is_neg  = res[DATA_W-1];
endmodule

// File: rtl/xst_seq.sv
module xst_seq
  import xst_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 20,
  parameter int DATA_W   = 32,
  parameter int RA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  addr20_en,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  output logic                  in_ready,
  output logic [RA_W-1:0]       rf_rd_addr,
  input  logic [DATA_W-1:0]     rf_rd_data,
  output logic                  rf_wr_en,
  output logic [RA_W-1:0]       rf_wr_addr,
  output logic [DATA_W-1:0]     rf_wr_data,
  output logic                  mem_wr_valid,
  input  logic                  mem_wr_ready,
  output logic [ADDR_W-1:0]     mem_wr_addr,
  output logic [DATA_W/2-1:0]   mem_wr_data,
  output logic [DATA_W/16-1:0]  mem_wr_strb,
  output logic                  range_err,
  output logic                  illegal_op,
  output logic                  flag_z,
  output logic                  flag_n,
  output logic                  flag_c,
  output logic                  flag_v,
  output logic                  flag_vt,
  output logic                  flag_st
);
  localparam int WORD_W     = DATA_W / 2;
  localparam int SB_W       = WORD_W / 8;
  localparam int DISP_BYTES = ADDR_W / 8;
  localparam int CW         = $clog2(DISP_BYTES + 1);

  sq_state_e         state;
  logic              is_word, is_idx;
  logic [RA_W-1:0]   areg, sreg;
  logic [ADDR_W-1:0] disp_q, ea_q, ea_nxt;
  logic [CW-1:0]     dcnt;
  logic              oor;
  logic [DATA_W-1:0] sx_res;
  logic              sx_zero, sx_neg;
  logic              take;
  logic              unused_rd;

  assign unused_rd = ^rf_rd_data[DATA_W-1:ADDR_W];

  assign in_ready = (state == SQ_OPC) || (state == SQ_AREG) || (state == SQ_DISP) ||
                    (state == SQ_SREG) || (state == SQ_XREG);
  assign take     = in_valid & in_ready;

  xst_ea_calc #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_ea (
    .base         (rf_rd_data[ADDR_W-1:0]),
    .disp         (disp_q),
    .use_disp     (is_idx),
    .narrow       (addr20_en),
    .ea           (ea_nxt),
    .out_of_range (oor)
  );

  xst_sext #(.DATA_W(DATA_W)) u_sx (
    .val     (rf_rd_data),
    .res     (sx_res),
    .is_zero (sx_zero),
    .is_neg  (sx_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= SQ_OPC;
      is_word      <= 1'b0;
      is_idx       <= 1'b0;
      areg         <= '0;
      sreg         <= '0;
      disp_q       <= '0;
      ea_q         <= '0;
      dcnt         <= '0;
      rf_rd_addr   <= '0;
      rf_wr_en     <= 1'b0;
      rf_wr_addr   <= '0;
      rf_wr_data   <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      mem_wr_strb  <= '0;
      range_err    <= 1'b0;
      illegal_op   <= 1'b0;
      flag_z       <= 1'b0;
      flag_n       <= 1'b0;
      flag_c       <= 1'b0;
      flag_v       <= 1'b0;
      flag_vt      <= 1'b0;
      flag_st      <= 1'b0;
    end else begin
      rf_wr_en   <= 1'b0;
      range_err  <= 1'b0;
      illegal_op <= 1'b0;
      case (state)
        SQ_OPC: if (take) begin
          is_word <= ~in_data[1];
          is_idx  <= in_data[0];
          if (in_data == OPC_STW_IND || in_data == OPC_STW_IDX ||
              in_data == OPC_STB_IND || in_data == OPC_STB_IDX)
            state <= SQ_AREG;
          else if (in_data == OPC_SEXT)
            state <= SQ_XREG;
          else
            illegal_op <= 1'b1;
        end
        SQ_AREG: if (take) begin
          areg   <= in_data[RA_W-1:0];
          dcnt   <= '0;
          disp_q <= '0;
          state  <= is_idx ? SQ_DISP : SQ_SREG;
        end
        SQ_DISP: if (take) begin
          disp_q <= {in_data, disp_q[ADDR_W-1:8]};
          dcnt   <= dcnt + 1'b1;
          if (dcnt == CW'(DISP_BYTES - 1)) state <= SQ_SREG;
        end
        SQ_SREG: if (take) begin
          sreg       <= in_data[RA_W-1:0];
          rf_rd_addr <= areg;
          state      <= SQ_BASE;
        end
        SQ_BASE: begin
          if (oor) begin
            range_err <= 1'b1;
            state     <= SQ_OPC;
          end else begin
            ea_q       <= ea_nxt;
            rf_rd_addr <= sreg;
            state      <= SQ_SRC;
          end
        end
        SQ_SRC: begin
          mem_wr_valid <= 1'b1;
          mem_wr_addr  <= ea_q;
          mem_wr_data  <= is_word ? rf_rd_data[WORD_W-1:0]
                                  : {{(WORD_W-8){1'b0}}, rf_rd_data[7:0]};
          mem_wr_strb  <= is_word ? {SB_W{1'b1}} : {{(SB_W-1){1'b0}}, 1'b1};
          state        <= SQ_WAIT;
        end
        SQ_WAIT: if (mem_wr_ready) begin
          mem_wr_valid <= 1'b0;
          state        <= SQ_OPC;
        end
        SQ_XREG: if (take) begin
          rf_rd_addr <= in_data[RA_W-1:0];
          state      <= SQ_XRD;
        end
        SQ_XRD: begin
          rf_wr_en   <= 1'b1;
          rf_wr_addr <= rf_rd_addr;
          rf_wr_data <= sx_res;
          flag_z     <= sx_zero;
          flag_n     <= sx_neg;
          flag_c     <= 1'b0;
          flag_v     <= 1'b0;
          state      <= SQ_OPC;
        end
        default: state <= SQ_OPC;
      endcase
    end
  end
endmodule

// File: rtl/xst_seq_chk.sv
module xst_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_ready,
  input logic                 mem_wr_valid,
  input logic                 mem_wr_ready,
  input logic [ADDR_W-1:0]    mem_wr_addr,
  input logic [DATA_W/2-1:0]  mem_wr_data,
  input logic [DATA_W/16-1:0] mem_wr_strb,
  input logic                 rf_wr_en,
  input logic                 range_err,
  input logic                 illegal_op,
  input logic                 flag_z,
  input logic                 flag_n,
  input logic                 flag_c,
  input logic                 flag_v,
  input logic                 flag_vt,
  input logic                 flag_st
);
  localparam int SB_W = DATA_W / 16;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) &&
    $stable(mem_wr_data) && $stable(mem_wr_strb)); // R7
  AST_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> !in_ready); // R7
  AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_strb == {SB_W{1'b1}} || mem_wr_strb == SB_W'(1))); // R6
  AST_BYTE_PAD: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && mem_wr_strb == SB_W'(1) |-> mem_wr_data[DATA_W/2-1:8] == '0); // R6
  AST_SEXT_CV: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> !flag_c && !flag_v); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    $stable({flag_vt, flag_st})); // R9
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rf_wr_en |-> $stable({flag_z, flag_n, flag_c, flag_v})); // R10
  AST_ERR_NO_WR: assert property (@(posedge clk) disable iff (rst)
    range_err |-> !mem_wr_valid && !rf_wr_en); // R5
  AST_ILL_NO_WR: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> !mem_wr_valid && !rf_wr_en); // R11
endmodule

bind xst_seq xst_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .mem_wr_strb(mem_wr_strb), .rf_wr_en(rf_wr_en), .range_err(range_err),
  .illegal_op(illegal_op), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
  .flag_v(flag_v), .flag_vt(flag_vt), .flag_st(flag_st)
);

// File: tb/xst_seq_tb_top.sv
`timescale 1ns/1ps
module xst_seq_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic init_rf = 1;
  logic addr20_en = 0;
  logic in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready;
  logic [7:0] rf_rd_addr;
  logic [31:0] rf_rd_data;
  logic rf_wr_en;
  logic [7:0] rf_wr_addr;
  logic [31:0] rf_wr_data;
  logic mem_wr_valid;
  logic mem_wr_ready = 0;
  logic [23:0] mem_wr_addr;
  logic [15:0] mem_wr_data;
  logic [1:0] mem_wr_strb;
  logic range_err, illegal_op;
  logic flag_z, flag_n, flag_c, flag_v, flag_vt, flag_st;

  always #2.5 clk = ~clk;

  xst_seq dut_i (
    .clk(clk), .rst(rst), .addr20_en(addr20_en), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_strb(mem_wr_strb), .range_err(range_err),
    .illegal_op(illegal_op), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
    .flag_v(flag_v), .flag_vt(flag_vt), .flag_st(flag_st)
  );

  function automatic logic [31:0] init_val(int i);
    if (i == 8'h40) return 32'h1234_8001;
    if (i == 8'h41) return 32'h5555_7FFF;
    if (i == 8'h42) return 32'hABCD_0000;
    if (i == 8'h30) return 32'h0000_0010;
    if (i == 8'h31) return 32'h00FF_FFF0;
    return {8'(i * 7 + 1), 8'(i ^ 8'h96), 8'(i * 3), 8'(i + 5)};
  endfunction

  // register file: asynchronous read, written on clock edge
  logic [31:0] rf_mem [0:255];
  assign rf_rd_data = rf_mem[rf_rd_addr];
  always @(posedge clk) begin
    if (init_rf) begin
      for (int i = 0; i < 256; i++) rf_mem[i] <= init_val(i);
    end else if (rf_wr_en) begin
      rf_mem[rf_wr_addr] <= rf_wr_data;
    end
  end

  // reference model state
  logic [31:0] shadow [0:255];
  logic [23:0] q_addr[$];
  logic [15:0] q_data[$];
  logic [1:0]  q_strb[$];
  int          q_tag[$];
  logic [7:0]  x_reg[$];
  logic [31:0] x_val[$];
  bit          x_z[$];
  bit          x_n[$];
  int exp_err = 0, exp_ill = 0;
  bit m_z = 0, m_n = 0, m_c = 0, m_v = 0;
  int checks = 0, errors = 0;
  bit p_stall = 0;
  logic [23:0] p_addr;
  logic [15:0] p_data;
  logic [1:0]  p_strb;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst) begin
      m_z = 0; m_n = 0; m_c = 0; m_v = 0; p_stall = 0;
    end else begin
      if (mem_wr_valid) begin
        chk(!in_ready, "R7", "in_ready during pending write", {31'b0, in_ready}, 0);
        if (p_stall) begin
          chk(mem_wr_addr == p_addr && mem_wr_data == p_data && mem_wr_strb == p_strb,
              "R7", "request changed while stalled", {mem_wr_addr, mem_wr_strb, 6'b0},
              {p_addr, p_strb, 6'b0});
        end
        if (mem_wr_ready) begin
          if (q_addr.size() == 0) begin
            chk(0, "R1", "unexpected write", {8'b0, mem_wr_addr}, 0);
          end else begin
            int tg;
            logic [23:0] ea;
            logic [15:0] dt;
            logic [1:0]  sb;
            tg = q_tag.pop_front();
            ea = q_addr.pop_front();
            dt = q_data.pop_front();
            sb = q_strb.pop_front();
            chk(mem_wr_addr == ea, $sformatf("R%0d", tg), "write address",
                {8'b0, mem_wr_addr}, {8'b0, ea});
            chk(mem_wr_data == dt && mem_wr_strb == sb, "R6", "write data/strobe",
                {14'b0, mem_wr_strb, mem_wr_data}, {14'b0, sb, dt});
          end
        end
      end
      p_stall = mem_wr_valid && !mem_wr_ready;
      p_addr = mem_wr_addr; p_data = mem_wr_data; p_strb = mem_wr_strb;

      if (rf_wr_en) begin
        if (x_reg.size() == 0) begin
          chk(0, "R8", "unexpected register write", rf_wr_data, 0);
        end else begin
          logic [7:0]  r;
          logic [31:0] v;
          r = x_reg.pop_front();
          v = x_val.pop_front();
          m_z = x_z.pop_front();
          m_n = x_n.pop_front();
          m_c = 0; m_v = 0;
          chk(rf_wr_addr == r, "R8", "write-back register", {24'b0, rf_wr_addr}, {24'b0, r});
          chk(rf_wr_data == v, "R8", "sign-extended value", rf_wr_data, v);
        end
      end
      chk({flag_z, flag_n, flag_c, flag_v, flag_vt, flag_st} == {m_z, m_n, m_c, m_v, 2'b00},
          rf_wr_en ? "R9" : "R10", "flags",
          {26'b0, flag_z, flag_n, flag_c, flag_v, flag_vt, flag_st},
          {26'b0, m_z, m_n, m_c, m_v, 2'b00});
      if (range_err) begin
        chk(exp_err > 0, "R5", "unexpected range_err", 1, 0);
        if (exp_err > 0) exp_err--;
      end
      if (illegal_op) begin
        chk(exp_ill > 0, "R11", "unexpected illegal_op", 1, 0);
        if (exp_ill > 0) exp_ill--;
      end
    end
  end

  // write acceptance with random back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      mem_wr_ready = ($urandom % 3) == 0;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk); #1;
    if ($urandom % 4 == 0) begin @(posedge clk); #1; end
    in_valid = 1; in_data = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk);
    while (q_addr.size() != 0 || x_reg.size() != 0 || exp_err != 0 || exp_ill != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_store(input bit word, input bit idx, input logic [7:0] a,
                          input logic [7:0] s, input logic [23:0] d);
    longint sd, sum;
    send_byte(word ? (idx ? 8'h1D : 8'h1C) : (idx ? 8'h1F : 8'h1E));
    send_byte(a);
    if (idx) begin
      send_byte(d[7:0]); send_byte(d[15:8]); send_byte(d[23:16]);
    end
    send_byte(s);
    sd = d[23] ? longint'(d) - 64'sd16777216 : longint'(d);
    if (!idx) sd = 0;
    if (addr20_en && idx && (sd < -524288 || sd > 524287)) begin
      exp_err++;
    end else begin
      sum = longint'(shadow[a][23:0]) + sd;
      q_addr.push_back(addr20_en ? 24'(sum & 64'hFFFFF) : 24'(sum & 64'hFFFFFF));
      q_data.push_back(word ? shadow[s][15:0] : {8'h00, shadow[s][7:0]});
      q_strb.push_back(word ? 2'b11 : 2'b01);
      q_tag.push_back(idx ? (addr20_en ? 4 : 3) : 2);
    end
    wait_idle();
  endtask

  task automatic do_ext(input logic [7:0] r);
    logic [31:0] v;
    send_byte(8'h06);
    send_byte(r);
    v = shadow[r];
    v = {v[15] ? 16'hFFFF : 16'h0000, v[15:0]};
    shadow[r] = v;
    x_reg.push_back(r); x_val.push_back(v);
    x_z.push_back(v == 0); x_n.push_back(v[31]);
    wait_idle();
  endtask

  task automatic do_illegal(input logic [7:0] op);
    send_byte(op);
    exp_ill++;
    wait_idle();
  endtask

  task automatic check_reset_state();
    @(negedge clk);
    chk(in_ready == 1, "R12", "in_ready after reset", {31'b0, in_ready}, 1);
    chk(mem_wr_valid == 0 && rf_wr_en == 0, "R12", "no request after reset",
        {30'b0, mem_wr_valid, rf_wr_en}, 0);
    chk({flag_z, flag_n, flag_c, flag_v, flag_vt, flag_st} == 6'b0, "R12", "flags after reset",
        {26'b0, flag_z, flag_n, flag_c, flag_v, flag_vt, flag_st}, 0);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    repeat (3) @(posedge clk);
    #1 rst = 0; init_rf = 0;
    check_reset_state();

    // R8 R9: sign extension, negative, positive, zero result, repeat
    do_ext(8'h40);
    do_ext(8'h41);
    do_ext(8'h42);
    do_ext(8'h40);

    // R1 R2 R6 R10: indirect forms, flags must hold the Z=0/N=1 state
    do_ext(8'h40);
    do_store(1, 0, 8'h10, 8'h20, 24'h0);
    do_store(0, 0, 8'h11, 8'h21, 24'h0);
    // R3: indexed, positive, negative with wrap, large positive in wide mode
    do_store(1, 1, 8'h12, 8'h40, 24'h000123);
    do_store(0, 1, 8'h30, 8'h22, 24'hFFFFE0);
    do_store(1, 1, 8'h13, 8'h23, 24'h080000);
    do_store(0, 1, 8'h31, 8'h24, 24'h000020);

    // R11: unknown opcodes, then a normal store decodes correctly
    do_illegal(8'h00);
    do_illegal(8'hFF);
    do_illegal(8'h1B);
    do_store(0, 0, 8'h14, 8'h25, 24'h0);

    // R4 R5: narrow addressing
    addr20_en = 1;
    do_store(1, 1, 8'h31, 8'h26, 24'h000020);
    do_store(0, 1, 8'h15, 8'h27, 24'h07FFFF);
    do_store(1, 1, 8'h16, 8'h28, 24'hF80000);
    do_store(1, 1, 8'h17, 8'h29, 24'h080000);
    do_store(0, 1, 8'h18, 8'h2A, 24'hF7FFFF);
    do_store(1, 0, 8'h31, 8'h2B, 24'h0);
    addr20_en = 0;

    // R12: reset in the middle of an indexed store
    send_byte(8'h1D);
    send_byte(8'h12);
    send_byte(8'h55);
    @(posedge clk); #1 rst = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    check_reset_state();
    do_store(1, 0, 8'h19, 8'h2C, 24'h0);
    do_ext(8'h41);

    chk(q_addr.size() == 0, "R1", "missing writes", q_addr.size(), 0);
    chk(x_reg.size() == 0, "R8", "missing write-backs", x_reg.size(), 0);
    chk(exp_err == 0, "R5", "missing range_err", exp_err, 0);
    chk(exp_ill == 0, "R11", "missing illegal_op", exp_ill, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule